// File: doc/BRIEF.md
# Low-Power Operating Mode Sequencer

This block keeps track of which of six power modes a low-power radio chip is in, and moves between them on the events that can end each mode. It works from two supply comparator flags, reset requests, timer expiry strobes, wake pins, an external interrupt and sleep requests from the CPU. From the current mode it drives the enables of the switched supply domains, a supply-on-reset pulse, a clock-source select, and two flags. One flag says the radio settings must be rewritten. The other says all register and memory content must be rebuilt.

A single timer expiry can mean different things depending on the mode. A watchdog or flywheel expiry normally triggers a full supply-on-reset. In flywheel sleep, however, the flywheel expiry is an ordinary wake. Each sleep mode also accepts only its own set of wake sources. When the CPU asks to sleep while an autonomous transmission is still running, the block parks in standby. It moves on to the requested sleep mode once the packet has finished.

Top module: `pm_mode_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the mode is OFF (code 0), the supply-on-reset output is low, every domain enable is low, the clock select points at the RC oscillator (`clk_rc`=1), and both loss flags and the error flag are low.
- R2: When `sup_below_off` is high at a clock edge, the block is in OFF after that edge, whatever mode it was in and whatever other inputs are active. Any supply-on-reset pulse is cut short, and the flags are cleared.
- R3: The only way out of OFF is `sup_above_on`. It starts a supply-on-reset pulse that lasts exactly SOR_CYCLES cycles, enters CPU mode (code 5) on the RC clock, and sets both loss flags. With the supply between the two thresholds, OFF is held.
- R4: In any mode other than OFF, `hw_rst` or `sw_rst` starts or restarts the supply-on-reset pulse. While the pulse is high, the mode is CPU, and timers, wake pins, the interrupt, sleep requests and the crystal select are all ignored.
- R5: In Standby (code 4), `gpt_expire` or `ext_irq` returns the block to CPU with the clock select and flags unchanged. A watchdog or flywheel expiry instead causes a supply-on-reset.
- R6: In ShortTerm Sleep (code 3), `stt_expire` returns the block to CPU on the RC clock and sets `radio_lost` while leaving `state_lost` as it was. A watchdog or flywheel expiry causes a supply-on-reset. Wake pins and the interrupt have no effect.
- R7: In Flywheel Sleep (code 2), a flywheel expiry or any wake pin returns the block to CPU on the RC clock with both loss flags set and no supply-on-reset pulse. A watchdog expiry causes a supply-on-reset.
- R8: In Deep Sleep (code 1), a watchdog expiry or any wake pin causes a supply-on-reset. The flywheel, short-term and general-purpose timers and the interrupt have no effect.
- R9: `dvdd_en` and `rvdd_en` are high only in Standby and CPU. `ram_en` is high in every mode except OFF.
- R10: In CPU mode, a sleep request whose `sleep_dest` is 1 (Deep), 2 (Flywheel), 3 (ShortTerm) or 4 (Standby) is accepted, and accepting it clears both loss flags and the error flag. Any other code leaves the mode unchanged and sets `dest_err`, which stays set until the next accepted request, supply-on-reset or OFF.
- R11: A request accepted while `tx_active` is high, for a destination other than Standby, enters Standby and remembers the destination. The block goes to that destination at the first edge where `tx_active` is low, unless a Standby wake comes first.
- R12: In CPU mode with no reset pulse and no sleep request, `xo_select` switches the clock select to the crystal (`clk_rc`=0). Standby keeps the current selection. Entering Deep, Flywheel or ShortTerm Sleep selects the RC clock.
- R13: When events coincide, supply loss wins over reset sources, reset sources win over timer expiries, and timer expiries win over wake pins and the interrupt. Among timers, the watchdog comes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_on | input | 1 | Supply is above the turn-on threshold |
| sup_below_off | input | 1 | Supply is at or below the turn-off threshold |
| hw_rst | input | 1 | Hardware reset pin, active high |
| sw_rst | input | 1 | Software reset command |
| sleep_req | input | 1 | CPU request to leave CPU mode |
| sleep_dest | input | 3 | Requested destination mode code |
| tx_active | input | 1 | Autonomous packet transmission in progress |
| xo_select | input | 1 | CPU request to run on the crystal clock |
| wdt_expire | input | 1 | Watchdog timer expiry strobe |
| fwt_expire | input | 1 | Flywheel timer expiry strobe |
| stt_expire | input | 1 | Short-term timer expiry strobe |
| gpt_expire | input | 1 | General-purpose timer expiry strobe |
| ext_irq | input | 1 | External interrupt |
| wake_pin | input | WAKE_PINS | Wake pins |
| sor | output | 1 | Supply-on-reset pulse |
| mode | output | 3 | Current mode code |
| clk_rc | output | 1 | 1 selects the RC oscillator, 0 the crystal |
| dvdd_en | output | 1 | Main digital supply enable |
| rvdd_en | output | 1 | RF supply enable |
| ram_en | output | 1 | Retention RAM supply enable |
| radio_lost | output | 1 | Radio configuration must be reloaded |
| state_lost | output | 1 | All register and memory content must be rebuilt |
| dest_err | output | 1 | Last sleep request carried an invalid destination |

## Verification
The bench sets SOR_CYCLES to 3 instead of the default 4. A length check that passes only because it matches the default therefore fails, and the shorter pulse lets the random phase reach many more sleep and wake transitions. WAKE_PINS stays at 2, so the bench can drive each wake pin on its own and check that either one alone, or both together, wakes Flywheel and Deep Sleep. With the supply band moving slowly at random, supply loss occurs in every mode and also during pending transmissions and live reset pulses.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

    typedef enum logic [2:0] {
        PM_OFF   = 3'd0,
        PM_DEEP  = 3'd1,
        PM_FLY   = 3'd2,
        PM_SHORT = 3'd3,
        PM_STBY  = 3'd4,
        PM_CPU   = 3'd5
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        pm_mode_e held_dest;
        logic     pend;
        logic     on_rc;
        logic     radio_lost;
        logic     state_lost;
        logic     dest_err;
    } pm_state_t;

    typedef struct packed {
        logic       sup_hi;
        logic       sup_lo;
        logic       hw_rst;
        logic       sw_rst;
        logic       sleep_req;
        logic [2:0] dest;
        logic       tx_busy;
        logic       xo_sel;
        logic       wdt;
        logic       fwt;
        logic       stt;
        logic       gpt;
        logic       irq;
        logic       wake;
    } pm_evt_t;

    typedef struct packed {
        logic dvdd;
        logic rvdd;
        logic ram;
    } pm_rail_t;

    function automatic pm_state_t idle_state();
        pm_state_t s;
        s.mode       = PM_OFF;
        s.held_dest  = PM_DEEP;
        s.pend       = 1'b0;
        s.on_rc      = 1'b1;
        s.radio_lost = 1'b0;
        s.state_lost = 1'b0;
        s.dest_err   = 1'b0;
        return s;
    endfunction

    function automatic pm_state_t after_sor(pm_state_t s);
        pm_state_t r = s;
        r.mode       = PM_CPU;
        r.pend       = 1'b0;
        r.on_rc      = 1'b1;
        r.radio_lost = 1'b1;
        r.state_lost = 1'b1;
        r.dest_err   = 1'b0;
        return r;
    endfunction

    function automatic logic dest_ok(logic [2:0] d);
        return (d >= 3'd1) && (d <= 3'd4);
    endfunction

    function automatic pm_rail_t rails_for(pm_mode_e m);
        pm_rail_t r;
        r.dvdd = (m == PM_STBY) || (m == PM_CPU);
        r.rvdd = r.dvdd;
        r.ram  = (m != PM_OFF);
        return r;
    endfunction

endpackage

// File: rtl/pm_sor_timer.sv
`timescale 1ns/1ps
module pm_sor_timer #(
    parameter int unsigned SOR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic kill,
    output logic busy
);
    localparam int unsigned CW = $clog2(SOR_CYCLES + 1);

    logic [CW-1:0] cnt;

    // R3 R4: fixed-length pulse, restarted by a new trigger, cut by supply loss
    always_ff @(posedge clk) begin
        if (rst || kill)
            cnt <= '0;
        else if (fire)
            cnt <= CW'(SOR_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/pm_mode_arb.sv
`timescale 1ns/1ps
module pm_mode_arb
    import pm_pkg::*;
(
    input  pm_state_t cur,
    input  pm_evt_t   ev,
    input  logic      sor_busy,
    output pm_state_t nxt,
    output logic      fire,
    output logic      kill
);
    always_comb begin
        nxt  = cur;
        fire = 1'b0;
        kill = 1'b0;
        if (ev.sup_lo) begin
            // R2 R13: supply loss dominates
            kill = 1'b1;
            nxt  = idle_state();
        end else if (cur.mode == PM_OFF) begin
            fire = ev.sup_hi;                        // R3
        end else if (ev.hw_rst || ev.sw_rst) begin
            fire = 1'b1;                             // R4
        end else if (!sor_busy) begin
            case (cur.mode)
                PM_CPU: begin
                    if (ev.wdt || ev.fwt) begin
                        fire = 1'b1;
                    end else if (ev.sleep_req) begin
                        if (dest_ok(ev.dest)) begin  // R10
                            nxt.radio_lost = 1'b0;
                            nxt.state_lost = 1'b0;
                            nxt.dest_err   = 1'b0;
                            if (ev.tx_busy && pm_mode_e'(ev.dest) != PM_STBY) begin
                                nxt.mode      = PM_STBY;   // R11
                                nxt.pend      = 1'b1;
                                nxt.held_dest = pm_mode_e'(ev.dest);
                            end else begin
                                nxt.mode = pm_mode_e'(ev.dest);
                                if (pm_mode_e'(ev.dest) != PM_STBY)
                                    nxt.on_rc = 1'b1;      // R12
                            end
                        end else begin
                            nxt.dest_err = 1'b1;
                        end
                    end else if (ev.xo_sel) begin
                        nxt.on_rc = 1'b0;            // R12
                    end
                end
                PM_STBY: begin                       // R5
                    if (ev.wdt || ev.fwt) begin
                        fire = 1'b1;
                    end else if (ev.gpt || ev.irq) begin
                        nxt.mode = PM_CPU;
                        nxt.pend = 1'b0;
                    end else if (cur.pend && !ev.tx_busy) begin
                        nxt.mode  = cur.held_dest;   // R11
                        nxt.pend  = 1'b0;
                        nxt.on_rc = 1'b1;
                    end
                end
                PM_SHORT: begin                      // R6
                    if (ev.wdt || ev.fwt) begin
                        fire = 1'b1;
                    end else if (ev.stt) begin
                        nxt.mode       = PM_CPU;
                        nxt.on_rc      = 1'b1;
                        nxt.radio_lost = 1'b1;
                    end
                end
                PM_FLY: begin                        // R7
                    if (ev.wdt) begin
                        fire = 1'b1;
                    end else if (ev.fwt || ev.wake) begin
                        nxt.mode       = PM_CPU;
                        nxt.on_rc      = 1'b1;
                        nxt.radio_lost = 1'b1;
                        nxt.state_lost = 1'b1;
                    end
                end
                PM_DEEP: begin                       // R8
                    if (ev.wdt || ev.wake)
                        fire = 1'b1;
                end
                default: ;
            endcase
        end
        if (fire)
            nxt = after_sor(nxt);
    end
endmodule

// File: rtl/pm_mode_ctrl.sv
`timescale 1ns/1ps
module pm_mode_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned SOR_CYCLES = 4,
    parameter int unsigned WAKE_PINS  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sup_above_on,
    input  logic                 sup_below_off,
    input  logic                 hw_rst,
    input  logic                 sw_rst,
    input  logic                 sleep_req,
    input  logic [2:0]           sleep_dest,
    input  logic                 tx_active,
    input  logic                 xo_select,
    input  logic                 wdt_expire,
    input  logic                 fwt_expire,
    input  logic                 stt_expire,
    input  logic                 gpt_expire,
    input  logic                 ext_irq,
    input  logic [WAKE_PINS-1:0] wake_pin,
    output logic                 sor,
    output logic [2:0]           mode,
    output logic                 clk_rc,
    output logic                 dvdd_en,
    output logic                 rvdd_en,
    output logic                 ram_en,
    output logic                 radio_lost,
    output logic                 state_lost,
    output logic                 dest_err
);
    pm_state_t st, st_nxt;
    pm_evt_t   ev;
    pm_rail_t  rails;
    logic      fire, kill, sor_busy;

    always_comb begin
        ev.sup_hi    = sup_above_on;
        ev.sup_lo    = sup_below_off;
        ev.hw_rst    = hw_rst;
        ev.sw_rst    = sw_rst;
        ev.sleep_req = sleep_req;
        ev.dest      = sleep_dest;
        ev.tx_busy   = tx_active;
        ev.xo_sel    = xo_select;
        ev.wdt       = wdt_expire;
        ev.fwt       = fwt_expire;
        ev.stt       = stt_expire;
        ev.gpt       = gpt_expire;
        ev.irq       = ext_irq;
        ev.wake      = |wake_pin;
    end

    pm_mode_arb u_arb (
        .cur      (st),
        .ev       (ev),
        .sor_busy (sor_busy),
        .nxt      (st_nxt),
        .fire     (fire),
        .kill     (kill)
    );

    pm_sor_timer #(.SOR_CYCLES(SOR_CYCLES)) u_sor (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .kill (kill),
        .busy (sor_busy)
    );

    // R1: synchronous reset to OFF
    always_ff @(posedge clk) begin
        if (rst)
            st <= idle_state();
        else
            st <= st_nxt;
    end

    assign rails      = rails_for(st.mode);   // R9
    assign sor        = sor_busy;
    assign mode       = st.mode;
    assign clk_rc     = st.on_rc;
    assign dvdd_en    = rails.dvdd;
    assign rvdd_en    = rails.rvdd;
    assign ram_en     = rails.ram;
    assign radio_lost = st.radio_lost;
    assign state_lost = st.state_lost;
    assign dest_err   = st.dest_err;
endmodule

// File: rtl/pm_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pm_mode_ctrl_chk #(
    parameter int unsigned WAKE_PINS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sup_above_on,
    input logic                 sup_below_off,
    input logic                 hw_rst,
    input logic                 sw_rst,
    input logic                 sleep_req,
    input logic [2:0]           sleep_dest,
    input logic                 wdt_expire,
    input logic                 fwt_expire,
    input logic                 stt_expire,
    input logic                 gpt_expire,
    input logic                 ext_irq,
    input logic [WAKE_PINS-1:0] wake_pin,
    input logic                 sor,
    input logic [2:0]           mode,
    input logic                 clk_rc,
    input logic                 dvdd_en,
    input logic                 ram_en,
    input logic                 radio_lost,
    input logic                 state_lost,
    input logic                 dest_err
);
    logic quiet_rst;
    assign quiet_rst = !sup_below_off && !hw_rst && !sw_rst;

    AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (rst)
        sup_below_off |=> (mode == 3'd0 && !sor && !dvdd_en && !ram_en)); // R2

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 && !sup_above_on) |=> (mode == 3'd0 && !sor)); // R3

    AST_PULSE_IN_CPU: assert property (@(posedge clk) disable iff (rst)
        sor |-> (mode == 3'd5 && clk_rc)); // R4

    AST_RESET_PIN_SOR: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'd0 && !sup_below_off && hw_rst) |=> sor); // R4

    AST_STBY_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && quiet_rst && !wdt_expire && !fwt_expire && (gpt_expire || ext_irq))
        |=> (mode == 3'd5 && $stable(clk_rc) && $stable(radio_lost))); // R5

    AST_SHORT_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && quiet_rst && !wdt_expire && !fwt_expire && stt_expire)
        |=> (mode == 3'd5 && clk_rc && radio_lost && !sor)); // R6

    AST_FLY_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 && quiet_rst && !wdt_expire && (fwt_expire || wake_pin != '0))
        |=> (mode == 3'd5 && !sor && state_lost && radio_lost)); // R7

    AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd1 && !sup_below_off && wake_pin != '0) |=> sor); // R8

    AST_BAD_DEST: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && !sor && quiet_rst && !wdt_expire && !fwt_expire && sleep_req
         && (sleep_dest == 3'd0 || sleep_dest > 3'd4))
        |=> (mode == 3'd5 && dest_err)); // R10
endmodule

bind pm_mode_ctrl pm_mode_ctrl_chk #(.WAKE_PINS(WAKE_PINS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sup_above_on  (sup_above_on),
    .sup_below_off (sup_below_off),
    .hw_rst        (hw_rst),
    .sw_rst        (sw_rst),
    .sleep_req     (sleep_req),
    .sleep_dest    (sleep_dest),
    .wdt_expire    (wdt_expire),
    .fwt_expire    (fwt_expire),
    .stt_expire    (stt_expire),
    .gpt_expire    (gpt_expire),
    .ext_irq       (ext_irq),
    .wake_pin      (wake_pin),
    .sor           (sor),
    .mode          (mode),
    .clk_rc        (clk_rc),
    .dvdd_en       (dvdd_en),
    .ram_en        (ram_en),
    .radio_lost    (radio_lost),
    .state_lost    (state_lost),
    .dest_err      (dest_err)
);

// File: tb/pm_mode_ctrl_test.sv
`timescale 1ns/1ps
module pm_mode_ctrl_test;
    localparam int SORN = 3;
    localparam int NW   = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, sup_hi, sup_lo, hw, sw, slp, txb, xo, wdt, fwt, stt, gpt, irq;
    logic [2:0] dest;
    logic [NW-1:0] wk;
    logic sor, clk_rc, dvdd_en, rvdd_en, ram_en, radio_lost, state_lost, dest_err;
    logic [2:0] mode;

    pm_mode_ctrl #(.SOR_CYCLES(SORN), .WAKE_PINS(NW)) uut (
        .clk(clk), .rst(rst), .sup_above_on(sup_hi), .sup_below_off(sup_lo),
        .hw_rst(hw), .sw_rst(sw), .sleep_req(slp), .sleep_dest(dest),
        .tx_active(txb), .xo_select(xo), .wdt_expire(wdt), .fwt_expire(fwt),
        .stt_expire(stt), .gpt_expire(gpt), .ext_irq(irq), .wake_pin(wk),
        .sor(sor), .mode(mode), .clk_rc(clk_rc), .dvdd_en(dvdd_en),
        .rvdd_en(rvdd_en), .ram_en(ram_en), .radio_lost(radio_lost),
        .state_lost(state_lost), .dest_err(dest_err));

    int m_mode, m_cnt, m_pdest;
    bit m_rc, m_rl, m_sl, m_err, m_pend;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string tag = "R1";

    function automatic void m_reset();
        m_mode = 0; m_cnt = 0; m_rc = 1; m_rl = 0; m_sl = 0; m_err = 0; m_pend = 0; m_pdest = 1;
    endfunction

    function automatic void m_sor();
        m_mode = 5; m_cnt = SORN; m_rc = 1; m_rl = 1; m_sl = 1; m_err = 0; m_pend = 0;
    endfunction

    // reference behaviour written from the requirements
    function automatic void model_step();
        bit fire = 0;
        bit busy = (m_cnt != 0);
        bit anyw = (wk != '0);
        int d = int'(dest);
        if (rst) begin m_reset(); return; end
        if (sup_lo) begin m_reset(); return; end
        if (m_mode == 0) fire = sup_hi;
        else if (hw || sw) fire = 1;
        else if (!busy) begin
            case (m_mode)
                5: if (wdt || fwt) fire = 1;
                   else if (slp) begin
                       if (d >= 1 && d <= 4) begin
                           m_rl = 0; m_sl = 0; m_err = 0;
                           if (txb && d != 4) begin m_mode = 4; m_pend = 1; m_pdest = d; end
                           else begin m_mode = d; if (d != 4) m_rc = 1; end
                       end else m_err = 1;
                   end else if (xo) m_rc = 0;
                4: if (wdt || fwt) fire = 1;
                   else if (gpt || irq) begin m_mode = 5; m_pend = 0; end
                   else if (m_pend && !txb) begin m_mode = m_pdest; m_pend = 0; m_rc = 1; end
                3: if (wdt || fwt) fire = 1;
                   else if (stt) begin m_mode = 5; m_rc = 1; m_rl = 1; end
                2: if (wdt) fire = 1;
                   else if (fwt || anyw) begin m_mode = 5; m_rc = 1; m_rl = 1; m_sl = 1; end
                1: if (wdt || anyw) fire = 1;
                default: ;
            endcase
        end
        if (fire) m_sor();
        else if (m_cnt != 0) m_cnt--;
    endfunction

    function automatic logic [10:0] exp_vec();
        bit dv = (m_mode == 4 || m_mode == 5);
        return {3'(m_mode), m_cnt != 0, m_rc, dv, dv, m_mode != 0, m_rl, m_sl, m_err};
    endfunction

    task automatic step();
        logic [10:0] act, exp;
        @(posedge clk);
        @(negedge clk);
        model_step();
        act = {mode, sor, clk_rc, dvdd_en, rvdd_en, ram_en, radio_lost, state_lost, dest_err};
        exp = exp_vec();
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
    endtask

    task automatic lit(string t, int a, int e);
        n_chk++;
        if (a != e) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", t, a, e);
        end
    endtask

    task automatic clr_ev();
        hw = 0; sw = 0; slp = 0; xo = 0; wdt = 0; fwt = 0; stt = 0; gpt = 0; irq = 0; wk = '0;
    endtask

    task automatic req(int d);
        slp = 1; dest = 3'(d); step(); slp = 0;
    endtask

    task automatic settle();
        repeat (SORN + 1) step();
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_up();
    end

    initial begin
        int hi;
        rst = 1; sup_hi = 0; sup_lo = 0; txb = 0; dest = 0; clr_ev();
        m_reset();
        tag = "R1"; step(); step();
        rst = 0; step();
        lit("R1 mode", int'(mode), 0); lit("R1 clk_rc", int'(clk_rc), 1);

        tag = "R3"; step(); step();
        lit("R3 OFF held", int'(mode), 0);
        sup_hi = 1; step(); hi = int'(sor);
        lit("R3 enter CPU", int'(mode), 5);
        repeat (4) begin step(); hi += int'(sor); end
        lit("R3 pulse length", hi, SORN);

        tag = "R10"; req(0); lit("R10 bad code 0", int'(dest_err), 1);
        req(6); req(7); lit("R10 mode kept", int'(mode), 5);

        tag = "R12"; xo = 1; step(); xo = 0;
        lit("R12 crystal", int'(clk_rc), 0);

        tag = "R5"; req(4); lit("R9 standby rails", int'(dvdd_en), 1);
        gpt = 1; step(); gpt = 0;
        lit("R5 wake to CPU", int'(mode), 5); lit("R5 clock kept", int'(clk_rc), 0);
        req(4); irq = 1; step(); irq = 0; lit("R5 irq wake", int'(mode), 5);
        req(4); wdt = 1; step(); wdt = 0; lit("R5 watchdog SOR", int'(sor), 1);
        settle();

        tag = "R6"; req(3); lit("R9 short rails", int'(dvdd_en), 0);
        wk = 2'b11; step(); wk = '0; irq = 1; step(); irq = 0;
        lit("R6 pins ignored", int'(mode), 3);
        stt = 1; step(); stt = 0;
        lit("R6 radio lost", int'(radio_lost), 1); lit("R6 state kept", int'(state_lost), 0);
        req(3); fwt = 1; step(); fwt = 0; lit("R6 flywheel SOR", int'(sor), 1);
        settle();

        tag = "R7"; req(2); stt = 1; gpt = 1; step(); stt = 0; gpt = 0;
        lit("R7 short timer ignored", int'(mode), 2);
        wk = 2'b10; step(); wk = '0;
        lit("R7 pin wake", int'(mode), 5); lit("R7 no SOR", int'(sor), 0);
        lit("R7 state lost", int'(state_lost), 1);
        req(2); fwt = 1; step(); fwt = 0; lit("R7 flywheel wake", int'(sor), 0);
        req(2); wdt = 1; fwt = 1; step(); clr_ev(); lit("R7 R13 watchdog first", int'(sor), 1);
        settle();

        tag = "R8"; req(1); fwt = 1; stt = 1; gpt = 1; irq = 1; step(); clr_ev();
        lit("R8 ignored", int'(mode), 1); lit("R9 deep ram", int'(ram_en), 1);
        wk = 2'b01; step(); wk = '0; lit("R8 pin SOR", int'(sor), 1);
        settle(); req(1); wdt = 1; step(); wdt = 0; lit("R8 watchdog SOR", int'(sor), 1);
        settle();

        tag = "R11"; xo = 1; step(); xo = 0; txb = 1; req(3);
        lit("R11 parked", int'(mode), 4);
        step(); step(); lit("R11 still parked", int'(mode), 4);
        txb = 0; step(); lit("R11 destination", int'(mode), 3); lit("R11 RC clock", int'(clk_rc), 1);
        stt = 1; step(); stt = 0;
        txb = 1; req(1); gpt = 1; step(); gpt = 0; txb = 0; step();
        lit("R11 cancelled by wake", int'(mode), 5);

        tag = "R4"; sw = 1; step(); sw = 0; req(1);
        lit("R4 request ignored in pulse", int'(mode), 5);
        hw = 1; step(); hw = 0; step(); step();
        lit("R4 pulse restarted", int'(sor), 1);
        settle();

        tag = "R13"; hw = 1; sup_lo = 1; sup_hi = 0; step(); clr_ev();
        lit("R13 supply first", int'(mode), 0);
        sup_lo = 0; step(); lit("R2 OFF held", int'(mode), 0);
        sup_hi = 1; step(); settle();
        tag = "R2"; req(4); sup_lo = 1; step(); sup_lo = 0;
        lit("R2 from standby", int'(mode), 0);
        step();

        begin
            int band = 2;
            void'($urandom(32'd1357));
            tag = "R13 random";
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 60 == 0) band = int'($urandom % 3);
                sup_hi = (band == 2); sup_lo = (band == 0);
                hw  = ($urandom % 80 == 0); sw = ($urandom % 90 == 0);
                slp = ($urandom % 5 == 0);  dest = 3'($urandom % 8);
                if ($urandom % 10 == 0) txb = ~txb;
                xo  = ($urandom % 8 == 0);  wdt = ($urandom % 40 == 0);
                fwt = ($urandom % 25 == 0); stt = ($urandom % 6 == 0);
                gpt = ($urandom % 8 == 0);  irq = ($urandom % 12 == 0);
                wk  = ($urandom % 10 == 0) ? NW'($urandom) : '0;
                step();
            end
        end
        finish_up();
    end
endmodule